// File: doc/BRIEF.md
# Resonant Actuator Burst Sequencer

This block decides, cycle by cycle, which phase a linear resonant actuator is in during one vibration burst. A level enable input asks for vibration. Once the enable has been held long enough to count as real, the block runs a kick phase of programmable length in milliseconds, then a steady drive phase that lasts as long as the enable stays high. When the enable drops, an active brake phase follows. Its length repeats the time the burst was driven, up to a fixed ceiling, so short bursts get short brakes and long bursts get a full brake.

A downstream H-bridge waveform generator consumes four phase flags and a polarity request. During kick and drive, the polarity toggles every half of the configured resonance period. During braking, it is held at the inverse of the last drive value. A standby input forces the block idle, and after standby is released the enable is ignored for a guard interval. Time in milliseconds comes from a one-cycle tick input. Resonance timing and the guard are counted in clock cycles.

Top module: `lra_burst_seq`

## Requirements
- R1: While `stby_n` is sampled low, from the next cycle on `ph_idle` is 1, `ph_start`, `ph_drive` and `ph_brake` are 0, and `drive_pol` is 0.
- R2: After `stby_n` rises, the block stays idle for GUARD_CYC cycles whatever `en` does. An enable already high is then qualified as in R3, so `ph_start` first shows GUARD_CYC + 2·`half_cyc` + 1 cycles after the rise.
- R3: An enable high for 2·`half_cyc` cycles or fewer is dropped with no phase other than idle. The enable must be sampled high on 2·`half_cyc` + 1 consecutive edges to be accepted.
- R4: An accepted enable enters the kick phase (`ph_start`). That phase lasts for `start_ms` ticks and then hands over to `ph_drive`. When `start_ms` is 0, the block goes straight to `ph_drive`.
- R5: The drive phase holds for as long as `en` stays high, with or without ticks.
- R6: The block counts the ticks seen during kick and drive. When `en` falls with N ticks counted, where 0 < N < BRAKE_CAP, `ph_brake` holds for exactly N ticks and the block then returns to idle.
- R7: The drive tick count saturates at BRAKE_CAP, so any burst of BRAKE_CAP or more ticks is followed by a brake of exactly BRAKE_CAP ticks.
- R8: With `brake_off` = 1, a falling enable sends the block directly to idle with no brake phase.
- R9: An enable that rises during braking abandons the brake. The next cycle enters a fresh kick phase with the polarity restarted at 0.
- R10: On each entry to kick, `drive_pol` starts at 0. While kicking or driving, it toggles after every `half_cyc` clock cycles.
- R11: On entry to braking, `drive_pol` is the inverse of its value in the last drive cycle, and it stays constant for the whole brake.
- R12: An enable that falls before any tick was counted in the burst returns the block straight to idle.
- R13: Exactly one of the four phase flags is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stby_n | input | 1 | Standby control, low forces idle |
| en | input | 1 | Level vibration request |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| start_ms | input | STW | Kick phase length in ticks |
| half_cyc | input | HALFW | Half resonance period in clock cycles |
| brake_off | input | 1 | 1 disables the brake phase |
| ph_idle | output | 1 | Idle (also during guard and enable qualification) |
| ph_start | output | 1 | Kick phase active |
| ph_drive | output | 1 | Steady drive phase active |
| ph_brake | output | 1 | Brake phase active |
| drive_pol | output | 1 | Polarity request to the bridge generator |

## Verification
The bench builds the block with BRAKE_CAP = 5, GUARD_CYC = 4, HALFW = 4 and STW = 3, and runs it with `half_cyc` = 3 and `start_ms` = 2. A cap of five ticks lets bursts both below and beyond saturation be compared against the exact brake length in a few hundred cycles. The short guard and six-cycle resonance period make the qualification edge, the guard edge and each polarity toggle observable at exact cycle offsets.

// File: rtl/lra_seq_pkg.sv
package lra_seq_pkg;
  typedef enum logic [2:0] {
    PH_GUARD = 3'd0,
    PH_IDLE  = 3'd1,
    PH_QUAL  = 3'd2,
    PH_START = 3'd3,
    PH_DRIVE = 3'd4,
    PH_BRAKE = 3'd5
  } phase_e;
endpackage

// File: rtl/lra_rst_sync.sv
module lra_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lra_pol_gen.sv
module lra_pol_gen #(
  parameter int HALFW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [HALFW-1:0] half_cyc,
  output logic             pol
);
  logic [HALFW-1:0] hc_q, hc_d;
  logic             pol_d;
  logic [HALFW:0]   hc_inc;

  assign hc_inc = {1'b0, hc_q} + {{HALFW{1'b0}}, 1'b1};

  always_comb begin
    hc_d  = hc_q;
    pol_d = pol;
    if (restart) begin
      hc_d  = '0;
      pol_d = 1'b0;
    end else if (run) begin
      if (hc_inc >= {1'b0, half_cyc}) begin
        hc_d  = '0;
        pol_d = ~pol;
      end else begin
        hc_d = hc_inc[HALFW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      pol  <= 1'b0;
    end else if (run || restart) begin
      hc_q <= hc_d;
      pol  <= pol_d;
    end
  end

  // R11: polarity frozen whenever the generator is not running
  p_pol_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pol));
  // R10: a restart always lands on polarity 0
  p_restart_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !pol);
endmodule

// File: rtl/lra_burst_timer.sv
module lra_burst_timer #(
  parameter int BRAKE_CAP = 30,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr_acc,
  input  logic          acc_en,
  input  logic          load_brk,
  input  logic          brk_en,
  output logic [CW-1:0] drv_ms,
  output logic [CW-1:0] brk_left
);
  localparam logic [CW-1:0] CAP_V = CW'(BRAKE_CAP);

  logic [CW-1:0] drv_d, brk_d;

  always_comb begin
    drv_d = drv_ms;
    if (clr_acc)                             drv_d = '0;
    else if (acc_en && tick && drv_ms < CAP_V) drv_d = drv_ms + 1'b1;
  end

  always_comb begin
    brk_d = brk_left;
    if (load_brk)                                 brk_d = drv_ms;
    else if (brk_en && tick && brk_left != '0)    brk_d = brk_left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_ms   <= '0;
      brk_left <= '0;
    end else begin
      if (clr_acc || acc_en)   drv_ms   <= drv_d;
      if (load_brk || brk_en)  brk_left <= brk_d;
    end
  end

  // R7: drive time saturates at the cap
  p_drive_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ms <= CAP_V);
  // R7: the brake length never exceeds the cap
  p_brake_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_left <= CAP_V);
  // R6: a brake countdown only moves on a tick
  p_brake_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_brk) |=> $stable(brk_left));
endmodule

// File: rtl/lra_burst_seq.sv
module lra_burst_seq
  import lra_seq_pkg::*;
#(
  parameter int HALFW     = 12,
  parameter int STW       = 6,
  parameter int BRAKE_CAP = 30,
  parameter int GUARD_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_n,
  input  logic             en,
  input  logic             tick_ms,
  input  logic [STW-1:0]   start_ms,
  input  logic [HALFW-1:0] half_cyc,
  input  logic             brake_off,
  output logic             ph_idle,
  output logic             ph_start,
  output logic             ph_drive,
  output logic             ph_brake,
  output logic             drive_pol
);
  localparam int PERW = HALFW + 1;
  localparam int CW   = $clog2(BRAKE_CAP + 1);
  localparam int GW   = $clog2(GUARD_CYC + 1);
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYC - 1);

  logic          srst_n;
  phase_e        state, nstate;
  logic [GW-1:0]   gcnt, gcnt_d;
  logic [PERW-1:0] qcnt, qcnt_d;
  logic [STW-1:0]  st_cnt, st_d;
  logic [CW-1:0]   drv_ms, brk_left;
  logic            pol;
  logic            running, nrunning, enter_run;
  logic            qual_done, start_last, brake_go;
  phase_e          run_entry;

  lra_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign qual_done  = ({1'b0, qcnt} + {{PERW{1'b0}}, 1'b1}) >= {1'b0, half_cyc, 1'b0};
  assign start_last = ({1'b0, st_cnt} + {{STW{1'b0}}, 1'b1}) == {1'b0, start_ms};
  assign brake_go   = !brake_off && (drv_ms != '0);
  assign run_entry  = (start_ms == '0) ? PH_DRIVE : PH_START;

  always_comb begin
    nstate = state;
    gcnt_d = gcnt;
    qcnt_d = qcnt;
    st_d   = st_cnt;
    if (!stby_n) begin
      nstate = PH_GUARD;
      gcnt_d = '0;
    end else begin
      unique case (state)
        PH_GUARD: begin
          if (gcnt == GUARD_LAST) nstate = PH_IDLE;
          else                    gcnt_d = gcnt + 1'b1;
        end
        PH_IDLE: begin
          if (en) begin
            nstate = PH_QUAL;
            qcnt_d = '0;
          end
        end
        PH_QUAL: begin
          if (!en)            nstate = PH_IDLE;
          else if (qual_done) begin
            nstate = run_entry;
            st_d   = '0;
          end else            qcnt_d = qcnt + 1'b1;
        end
        PH_START: begin
          if (!en)                          nstate = brake_go ? PH_BRAKE : PH_IDLE;
          else if (tick_ms && start_last)   nstate = PH_DRIVE;
          else if (tick_ms)                 st_d   = st_cnt + 1'b1;
        end
        PH_DRIVE: begin
          if (!en) nstate = brake_go ? PH_BRAKE : PH_IDLE;
        end
        PH_BRAKE: begin
          if (en) begin
            nstate = run_entry;
            st_d   = '0;
          end else if (tick_ms && brk_left == CW'(1)) nstate = PH_IDLE;
        end
        default: nstate = PH_GUARD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state  <= PH_GUARD;
      gcnt   <= '0;
      qcnt   <= '0;
      st_cnt <= '0;
    end else begin
      state <= nstate;
      if (state == PH_GUARD || !stby_n) gcnt <= gcnt_d;
      if (state == PH_IDLE || state == PH_QUAL) qcnt <= qcnt_d;
      if (nstate == PH_START || state == PH_START) st_cnt <= st_d;
    end
  end

  assign running   = (state == PH_START) || (state == PH_DRIVE);
  assign nrunning  = (nstate == PH_START) || (nstate == PH_DRIVE);
  assign enter_run = nrunning && !running;

  lra_burst_timer #(.BRAKE_CAP(BRAKE_CAP), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (tick_ms),
    .clr_acc  (enter_run),
    .acc_en   (running && en),
    .load_brk (nstate == PH_BRAKE && state != PH_BRAKE),
    .brk_en   (state == PH_BRAKE && !en),
    .drv_ms   (drv_ms),
    .brk_left (brk_left)
  );

  lra_pol_gen #(.HALFW(HALFW)) u_pol (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (running && nrunning),
    .restart  (enter_run),
    .half_cyc (half_cyc),
    .pol      (pol)
  );

  assign ph_idle   = (state == PH_GUARD) || (state == PH_IDLE) || (state == PH_QUAL);
  assign ph_start  = (state == PH_START);
  assign ph_drive  = (state == PH_DRIVE);
  assign ph_brake  = (state == PH_BRAKE);
  assign drive_pol = running ? pol : (ph_brake ? ~pol : 1'b0);

  // R1: standby forces idle with no polarity request
  p_standby_idle_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !stby_n |=> (ph_idle && !drive_pol));
  // R2: leaving standby never drives at once
  p_guard_idle_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(stby_n) |=> ph_idle);
  // R8: a brake can only begin with braking enabled
  p_no_brake_off_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (ph_brake && !$past(ph_brake)) |-> !$past(brake_off));
  // R11: brake entry inverts the last drive polarity
  p_brake_invert_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (ph_brake && !$past(ph_brake)) |-> (drive_pol != $past(drive_pol)));
  // R11: polarity held through the brake
  p_brake_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (ph_brake && $past(ph_brake)) |-> $stable(drive_pol));
  // R13: exactly one phase flag
  p_one_phase_r13: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot({ph_idle, ph_start, ph_drive, ph_brake}));
endmodule

// File: tb/lra_burst_seq_test.sv
module lra_burst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALFW = 4;
  localparam int STW   = 3;
  localparam int CAP   = 5;
  localparam int GUARD = 4;
  localparam int HALF  = 3;
  localparam int PER   = 2 * HALF;
  localparam int NVEC  = 8;
  // {drive ticks[10:6], brake_off[5], expected brake ticks[4:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {5'd3,  1'b0, 5'd3},
    {5'd1,  1'b0, 5'd1},
    {5'd0,  1'b0, 5'd0},
    {5'd5,  1'b0, 5'd5},
    {5'd9,  1'b0, 5'd5},
    {5'd4,  1'b1, 5'd0},
    {5'd2,  1'b0, 5'd2},
    {5'd12, 1'b0, 5'd5}
  };

  logic clk = 1'b0;
  logic rst_n, stby_n, en, tick_ms, brake_off;
  logic [STW-1:0]   start_ms;
  logic [HALFW-1:0] half_cyc;
  logic ph_idle, ph_start, ph_drive, ph_brake, drive_pol;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lra_burst_seq #(.HALFW(HALFW), .STW(STW), .BRAKE_CAP(CAP), .GUARD_CYC(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .en(en), .tick_ms(tick_ms),
    .start_ms(start_ms), .half_cyc(half_cyc), .brake_off(brake_off),
    .ph_idle(ph_idle), .ph_start(ph_start), .ph_drive(ph_drive),
    .ph_brake(ph_brake), .drive_pol(drive_pol)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick;
    tick_ms = 1'b1;
    @(negedge clk);
    tick_ms = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; stby_n = 1'b1; en = 1'b0; tick_ms = 1'b0;
    brake_off = 1'b0; start_ms = 3'd2; half_cyc = 4'(HALF);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // reset state
    check("R13 reset idle", ph_idle, 1);
    check("R13 reset flags", {ph_start, ph_drive, ph_brake}, 0);
    check("R1 reset pol", drive_pol, 0);
    cyc(GUARD + 4);

    // vector table: burst length against brake length
    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] w;
      int n_ms, expb, cnt;
      string tag;
      w = VEC[v];
      n_ms = int'(w[10:6]);
      expb = int'(w[4:0]);
      brake_off = w[5];
      if (w[5])            tag = "R8";
      else if (n_ms == 0)  tag = "R12";
      else if (n_ms >= CAP) tag = "R7";
      else                 tag = "R6";
      en = 1'b1;
      cyc(PER);
      check("R3 qualifying", ph_idle, 1);
      cyc(1);
      check("R4 kick entry", ph_start, 1);
      for (int t = 0; t < n_ms; t++) pulse_tick();
      if (n_ms >= 2) begin
        check("R4 kick to drive", ph_drive, 1);
        cyc(7);
        check("R5 drive holds", ph_drive, 1);
      end else begin
        check("R4 kick holds", ph_start, 1);
      end
      en = 1'b0;
      cyc(1);
      if (expb == 0) begin
        check(tag, ph_idle, 1);
      end else begin
        check(tag, ph_brake, 1);
        cnt = 0;
        while (!ph_idle && cnt < 40) begin
          pulse_tick();
          cnt++;
        end
        check(tag, cnt, expb);
      end
      brake_off = 1'b0;
      cyc(2);
    end

    // R3: pulse of exactly one period is dropped
    begin
      int seen;
      en = 1'b1;
      cyc(PER);
      en = 1'b0;
      seen = 0;
      for (int k = 0; k < PER + 3; k++) begin
        cyc(1);
        if (!ph_idle) seen++;
      end
      check("R3 short pulse", seen, 0);
    end

    // R10: polarity toggles every HALF cycles from kick entry
    en = 1'b1;
    cyc(PER + 1);
    check("R10 entry", ph_start, 1);
    check("R10 pol entry", drive_pol, 0);
    cyc(HALF - 1);
    check("R10 pol before toggle", drive_pol, 0);
    cyc(1);
    check("R10 first toggle", drive_pol, 1);
    cyc(HALF - 1);
    check("R10 pol high", drive_pol, 1);
    cyc(1);
    check("R10 second toggle", drive_pol, 0);
    cyc(1);
    pulse_tick();
    pulse_tick();
    pulse_tick();
    // R11: brake inverts and holds
    begin
      int last;
      last = int'(drive_pol);
      en = 1'b0;
      cyc(1);
      check("R11 brake entry", ph_brake, 1);
      check("R11 inverted", drive_pol, 1 - last);
      cyc(HALF + 2);
      check("R11 held", drive_pol, 1 - last);
    end
    // R9: enable during brake restarts the kick
    en = 1'b1;
    cyc(1);
    check("R9 kick again", ph_start, 1);
    check("R9 pol restart", drive_pol, 0);
    en = 1'b0;
    cyc(1);
    check("R12 no ticks", ph_idle, 1);
    cyc(2);

    // R4: zero kick length goes straight to drive
    start_ms = 3'd0;
    en = 1'b1;
    cyc(PER + 1);
    check("R4 zero kick", ph_drive, 1);
    en = 1'b0;
    cyc(2);
    start_ms = 3'd2;

    // R1: standby in the middle of a drive
    en = 1'b1;
    cyc(PER + 1);
    pulse_tick();
    pulse_tick();
    check("R5 pre-standby", ph_drive, 1);
    stby_n = 1'b0;
    cyc(1);
    check("R1 standby idle", ph_idle, 1);
    check("R1 standby flags", {ph_start, ph_drive, ph_brake}, 0);
    check("R1 standby pol", drive_pol, 0);
    cyc(3);
    // R2: guard then qualification with enable held high
    stby_n = 1'b1;
    cyc(GUARD + PER);
    check("R2 guard plus qual", ph_idle, 1);
    cyc(1);
    check("R2 kick after guard", ph_start, 1);
    en = 1'b0;
    cyc(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule